// File: doc/BRIEF.md
# Single-Step Trace Interrupt Generator

This block produces the active-low non-maskable interrupt request that lets debug monitor firmware on an 8-bit microprocessor trace user code one instruction at a time. It watches the processor's opcode-fetch strobe (SYNC), the phase-2 clock qualifier and the 16-bit address bus. In single-step mode it pulls the interrupt line low whenever an opcode is fetched from an address below a protected upper window, where the monitor lives. Fetches inside the window pass untouched, so the monitor's own code never traps itself.

A two-position mode switch selects between free running and single stepping. The switch is taken as a clean level. It is synchronised to the system clock and applied only at an instruction boundary, that is, while SYNC is low. The processor responds to the falling edge of the interrupt line. The block therefore holds the line low only until SYNC drops and then releases it, so that the next qualifying fetch makes a new edge.

Top module: `step_trace_nmi`

## Requirements
- R1: While reset (rst_n low) is applied, nmi_n_o is high.
- R2: When the effective mode is run (mode_sw_i = 0), nmi_n_o stays high whatever the fetch activity.
- R3: When the effective mode is step (mode_sw_i = 1) and sync_i, phi2_i are both high at a rising clock edge with addr_i outside the window, nmi_n_o is low after that edge.
- R4: A cycle with sync_i low, or with phi2_i low, never pulls nmi_n_o low.
- R5: The protected window is every address from 0xA000 up to 0xFFFF. A fetch at 0x9FFF or below triggers the interrupt. A fetch at 0xA000 or above does not.
- R6: Once low, nmi_n_o stays low while sync_i stays high. It returns high at the first rising edge at which sync_i is low.
- R7: Every qualifying fetch that follows a release makes a new high-to-low transition of nmi_n_o.
- R8: A mode_sw_i change takes effect only after two synchronising flip-flops and only at a clock edge where sync_i is low. A change made while sync_i is held high is deferred until sync_i drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sw_i | input | 1 | Mode switch level: 1 = single step, 0 = run |
| sync_i | input | 1 | Opcode-fetch strobe from the processor |
| phi2_i | input | 1 | Phase-2 clock qualifier |
| addr_i | input | 16 | Processor address bus |
| nmi_n_o | output | 1 | Active-low non-maskable interrupt request |

## Verification
The bench fetches at both sides of the window boundary, 0x9FFF and 0xA000, plus 0x0200 and 0xFFFC. An off-by-one compare would trap the monitor's first byte or miss the last user byte. It holds SYNC high over several cycles to catch a design that releases early or pulses. It then re-fetches after the release to catch one that never produces a second edge. It flips the switch in the middle of a held fetch, and just before a fetch, to expose a design that changes mode mid-instruction or skips synchronisation. A randomised phase compares every cycle against a bench model of the same rules.

// File: rtl/step_trace_pkg.sv
package step_trace_pkg;
  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_STEP = 1'b1
  } run_mode_e;
endpackage

// File: rtl/stn_mode_sync.sv
module stn_mode_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_i,
  input  logic sync_i,
  output step_trace_pkg::run_mode_e mode_o
);
  import step_trace_pkg::*;

  logic [STAGES-1:0] chain_q;
  run_mode_e         mode_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= sw_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  // mode only changes between instructions (opcode strobe low)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_RUN;
    else if (!sync_i) mode_q <= run_mode_e'(chain_q[STAGES-1]);
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/stn_window_decode.sv
module stn_window_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_BASE = 'hA000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              outside_o
);
  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(WIN_BASE);

  // window runs from BASE_L to the top of the address space
  function automatic logic below_window(input logic [ADDR_W-1:0] a);
    return a < BASE_L;
  endfunction

  assign outside_o = below_window(addr_i);
endmodule

// File: rtl/stn_nmi_req.sv
module stn_nmi_req (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic fire_i,
  output logic nmi_n_o
);
  logic req_q;

  // held while the fetch strobe stays high, cleared when it drops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       req_q <= 1'b0;
    else if (!sync_i) req_q <= 1'b0;
    else if (fire_i)  req_q <= 1'b1;
  end

  assign nmi_n_o = ~req_q;
endmodule

// File: rtl/step_trace_nmi.sv
module step_trace_nmi #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned WIN_BASE    = 'hA000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sw_i,
  input  logic              sync_i,
  input  logic              phi2_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              nmi_n_o
);
  import step_trace_pkg::*;

  run_mode_e mode_w;
  logic      mode_step_w;
  logic      outside_w;
  logic      fire_w;

  stn_mode_sync #(.STAGES(SYNC_STAGES)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_i   (mode_sw_i),
    .sync_i (sync_i),
    .mode_o (mode_w)
  );

  stn_window_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_win (
    .addr_i    (addr_i),
    .outside_o (outside_w)
  );

  assign mode_step_w = (mode_w == MODE_STEP);
  assign fire_w      = mode_step_w & sync_i & phi2_i & outside_w;

  stn_nmi_req u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_i),
    .fire_i  (fire_w),
    .nmi_n_o (nmi_n_o)
  );
endmodule

// File: rtl/step_trace_nmi_chk.sv
module step_trace_nmi_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned WIN_BASE = 'hA000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_i,
  input logic              phi2_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              nmi_n_o,
  input logic              mode_step_w,
  input logic              outside_w
);
  localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(WIN_BASE);

  always_comb begin
    if (!rst_n) p_reset_high_r1: assert (nmi_n_o);
  end

  p_run_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_step_w |-> nmi_n_o);

  p_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_step_w && sync_i && phi2_i && outside_w) |=> !nmi_n_o);

  p_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_n_o && !(sync_i && phi2_i)) |=> nmi_n_o);

  p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_n_o && addr_i >= BASE_L) |=> nmi_n_o);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!nmi_n_o && sync_i) |=> !nmi_n_o);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_i |=> nmi_n_o);

  p_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> $stable(mode_step_w));
endmodule

bind step_trace_nmi step_trace_nmi_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_i      (sync_i),
  .phi2_i      (phi2_i),
  .addr_i      (addr_i),
  .nmi_n_o     (nmi_n_o),
  .mode_step_w (mode_step_w),
  .outside_w   (outside_w)
);

// File: tb/step_trace_nmi_tb.sv
module step_trace_nmi_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_sw = 1'b0;
  logic        sync = 1'b0;
  logic        phi2 = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        nmi_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  step_trace_nmi u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sw_i (mode_sw),
    .sync_i    (sync),
    .phi2_i    (phi2),
    .addr_i    (addr),
    .nmi_n_o   (nmi_n)
  );

  // bench view of the rules: trap below 0xA000, step = 1
  function automatic logic traps(input logic [15:0] a);
    return a <= 16'h9FFF;
  endfunction

  logic m1, m2, meff, mlow;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 1'b0; m2 <= 1'b0; meff <= 1'b0; mlow <= 1'b0;
    end else begin
      m1 <= mode_sw;
      m2 <= m1;
      if (!sync) meff <= m2;
      if (!sync) mlow <= 1'b0;
      else if (meff && phi2 && traps(addr)) mlow <= 1'b1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: nmi_n_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic s, input logic p, input logic [15:0] a);
    sync = s; phi2 = p; addr = a;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: expired, expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D2C3B4A));
    cyc(3);
    chk("R1 reset", nmi_n, 1'b1);
    sync = 1'b1; phi2 = 1'b1; mode_sw = 1'b1; cyc(3);
    chk("R1 reset with fetch", nmi_n, 1'b1);
    sync = 1'b0; phi2 = 1'b0; mode_sw = 1'b0;
    rst_n = 1'b1; cyc(4);

    drive(1, 1, 16'h0200); chk("R2 run mode fetch", nmi_n, 1'b1);
    drive(0, 0, 16'h0200);

    mode_sw = 1'b1; cyc(4);
    drive(1, 1, 16'h0200); chk("R3 step fetch 0x0200", nmi_n, 1'b0);
    drive(1, 0, 16'h0201); chk("R6 hold while sync high", nmi_n, 1'b0);
    drive(1, 1, 16'hA100); chk("R6 hold 2", nmi_n, 1'b0);
    drive(0, 1, 16'h0202); chk("R6 release", nmi_n, 1'b1);
    drive(1, 1, 16'h9FFF); chk("R5 0x9FFF traps", nmi_n, 1'b0);
    chk("R7 new edge after release", nmi_n, 1'b0);
    drive(0, 0, 16'h9FFF); chk("R6 release 2", nmi_n, 1'b1);
    drive(1, 1, 16'hA000); chk("R5 0xA000 passes", nmi_n, 1'b1);
    drive(0, 0, 16'hA000);
    drive(1, 1, 16'hFFFC); chk("R5 0xFFFC passes", nmi_n, 1'b1);
    drive(0, 0, 16'hFFFC);
    drive(1, 0, 16'h0200); chk("R4 phi2 low", nmi_n, 1'b1);
    drive(0, 1, 16'h0200); chk("R4 sync low", nmi_n, 1'b1);

    // switch to run while a fetch is held: mode must not change yet
    sync = 1'b1; phi2 = 1'b0; addr = 16'h0300; mode_sw = 1'b0; cyc(5);
    drive(1, 1, 16'h0300); chk("R8 change deferred during fetch", nmi_n, 1'b0);
    drive(0, 0, 16'h0300);
    drive(1, 1, 16'h0200); chk("R8 run applied at boundary", nmi_n, 1'b1);
    drive(0, 0, 16'h0200);

    // switch to step one cycle before a fetch: synchroniser not through
    mode_sw = 1'b1; cyc(1);
    drive(1, 1, 16'h0200); chk("R8 synchroniser latency", nmi_n, 1'b1);
    drive(1, 1, 16'h0200); chk("R8 still deferred", nmi_n, 1'b1);
    drive(0, 0, 16'h0200);
    drive(1, 1, 16'h0200); chk("R8 step applied", nmi_n, 1'b0);
    drive(0, 0, 16'h0200);

    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 3));
      logic [15:0] a;
      case (r)
        0: a = 16'h9FFF - 16'($urandom_range(0, 2));
        1: a = 16'hA000 + 16'($urandom_range(0, 2));
        default: a = 16'($urandom());
      endcase
      if ($urandom_range(0, 40) == 0) mode_sw = ~mode_sw;
      drive(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a);
      chk("R3/R6 random", nmi_n, ~mlow);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule